// File: doc/BRIEF.md
# Input Port Probe-Acknowledge Controller

This block sits at one inlet of a switch built from several parallel, unbuffered switching planes. It keeps arriving cells in a small first-in first-out queue. A cell leaves the head of the queue only after the fabric has confirmed that a path to the cell's outlet is free.

Time is divided into fixed slots, and each slot has three phases. In the first cycle the controller sends a probe naming the outlet that the head cell wants, along with the plane chosen for this attempt. During a short wait window it listens for an acknowledgment on that same plane. In the last cycle it sends the head cell and removes it from the queue, but only if the acknowledgment arrived. Without an acknowledgment the cell stays at the head and is tried again in the next slot.

The plane is selected in one of two ways:
- a fixed plane given on a port, for loading one plane only;
- a plane taken from a seeded shift-register sequence, for random loading across K planes.

Top module: `ipc_probe_ctrl`

## Requirements
- R1: After a synchronous active-low reset the queue is empty, `drop_cnt` is 0, no probe and no transmit are asserted, and the first cycle after reset is the first cycle of a slot.
- R2: A slot lasts ACK_WAIT+2 cycles: one probe cycle, ACK_WAIT wait cycles, then one data cycle. `slot_start` is high only in the probe cycle.
- R3: In every probe cycle with a non-empty queue, `probe_valid` is high and `probe_outlet` equals the outlet field of the head cell. With an empty queue no probe is issued.
- R4: An acknowledgment counts only if all three hold:
  - `ack_valid` is high in a wait cycle;
  - `ack_plane` equals the plane of this slot's probe;
  - a probe was issued in this slot.
  An acknowledgment in the probe cycle or the data cycle, on another plane, or in a slot without a probe has no effect.
- R5: When a slot's probe was acknowledged, in that slot's data cycle `tx_valid` is high and `tx_outlet`, `tx_data` and `tx_plane` equal the head cell and the probe's plane. The cell then leaves the queue.
- R6: Without an acknowledgment the head cell stays in the queue and is probed again in the next slot. Cells leave in arrival order.
- R7: An arrival (`in_valid` with `in_outlet`, `in_data`) is taken only in the probe cycle. `in_valid` in any other cycle is ignored, so the queue takes at most one write and one read per slot.
- R8: An arrival offered while the queue already holds DEPTH cells is discarded. `drop_cnt` then rises by one, saturating at its maximum, and the new value is visible from the next cycle on.
- R9: With `load_mode` = 0, `probe_plane` equals `fix_plane`.
- R10: With `load_mode` = 1, the plane is a 16-bit state taken modulo K.
  - The state is loaded from `lfsr_seed` during reset; a zero seed becomes 1.
  - The state advances once per slot, in every slot, at the end of the probe cycle.
  - The next state is {s[14:0], s[15]^s[13]^s[12]^s[10]}.
- R11: A slot whose probe cycle saw an empty queue asserts no `tx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lfsr_seed | input | 16 | Seed loaded into the plane sequence during reset |
| load_mode | input | 1 | 0: fixed plane, 1: random plane |
| fix_plane | input | PW | Plane used in fixed mode |
| in_valid | input | 1 | Arrival offered (taken in probe cycle only) |
| in_outlet | input | OUT_W | Requested outlet of the arriving cell |
| in_data | input | DATA_W | Payload of the arriving cell |
| slot_start | output | 1 | High in the probe cycle of each slot |
| probe_valid | output | 1 | Probe issued for the head cell |
| probe_outlet | output | OUT_W | Outlet carried by the probe |
| probe_plane | output | PW | Plane the probe is sent on |
| ack_valid | input | 1 | Acknowledgment returned from the fabric |
| ack_plane | input | PW | Plane the acknowledgment came back on |
| tx_valid | output | 1 | Head cell transmitted in this data cycle |
| tx_outlet | output | OUT_W | Outlet of the transmitted cell |
| tx_data | output | DATA_W | Payload of the transmitted cell |
| tx_plane | output | PW | Plane of the transmitted cell |
| drop_cnt | output | DROP_W | Saturating count of arrivals lost to a full queue |

## Verification
The queue write for an arrival and the issue of the probe for the current head happen in the same cycle, the slot's first.

Two consequences follow:
- An arrival into an empty queue must not be probed until the following slot.
- An arrival into a full queue is dropped even when the head cell leaves in that very slot's data cycle.

The bench provokes both by offering arrivals with high probability while withholding or granting acknowledgments slot by slot. It also sends acknowledgments on the wrong plane, in the probe cycle and in the data cycle. A reference queue, drop counter and plane sequence kept in the bench judge every probe, transmit and `drop_cnt` value.

// File: rtl/ipc_pkg.sv
// Package: shared types for the input port probe-acknowledge controller.
// Assumes nothing beyond being compiled before the modules that import it.
package ipc_pkg;

    // Phases of one switching slot.
    typedef enum logic [1:0] {
        PH_PROBE = 2'd0,
        PH_WAIT  = 2'd1,
        PH_XMIT  = 2'd2
    } phase_t;

    localparam int SEQ_W = 16;

    // One step of the 16-bit plane-selection shift register.
    function automatic logic [SEQ_W-1:0] seq_step(input logic [SEQ_W-1:0] s);
        return {s[SEQ_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/ipc_fifo.sv
// Module: cell queue holding DEPTH entries of W bits.
// Exposes the head entry combinationally.
// Assumes the caller never writes when full and never reads when empty.
module ipc_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] count;

    // Wrap a pointer at DEPTH, which need not be a power of two.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Storage write, no reset needed on the data.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (rd_en) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({wr_en, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // Head and flags.
    always_comb begin
        head  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end

endmodule

// File: rtl/ipc_slot_fsm.sv
// Module: slot sequencer.
// Steps through one probe cycle, ACK_WAIT wait cycles and one data cycle,
// then repeats. Assumes ACK_WAIT >= 1. Reset places it in the probe phase.
module ipc_slot_fsm
    import ipc_pkg::*;
#(
    parameter int ACK_WAIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_start,
    output logic in_wait,
    output logic in_xmit
);
    localparam int WW = (ACK_WAIT > 1) ? $clog2(ACK_WAIT) : 1;

    phase_t        phase;
    logic [WW-1:0] wcnt;

    // Phase advance with the wait-window counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_PROBE;
            wcnt  <= '0;
        end else begin
            case (phase)
                PH_PROBE: begin
                    phase <= PH_WAIT;
                    wcnt  <= '0;
                end
                PH_WAIT: begin
                    if (wcnt == WW'(ACK_WAIT - 1)) begin
                        phase <= PH_XMIT;
                    end
                    wcnt <= wcnt + WW'(1);
                end
                default: phase <= PH_PROBE;
            endcase
        end
    end

    // Phase decode.
    always_comb begin
        slot_start = (phase == PH_PROBE);
        in_wait    = (phase == PH_WAIT);
        in_xmit    = (phase == PH_XMIT);
    end

endmodule

// File: rtl/ipc_plane_sel.sv
// Module: plane selector.
// Gives either a fixed plane or a pseudo-random plane taken from a seeded
// 16-bit shift register, modulo K. Assumes advance pulses once per slot.
module ipc_plane_sel
    import ipc_pkg::*;
#(
    parameter int K  = 4,
    parameter int PW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEQ_W-1:0] seed,
    input  logic             advance,
    input  logic             rand_mode,
    input  logic [PW-1:0]    fix_plane,
    output logic [PW-1:0]    plane
);
    localparam logic [SEQ_W-1:0] KV = SEQ_W'(K);

    logic [SEQ_W-1:0] state;

    // Seed load during reset, one step per slot afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= (seed == '0) ? SEQ_W'(1) : seed;
        end else if (advance) begin
            state <= seq_step(state);
        end
    end

    // Mode multiplexer.
    always_comb begin
        plane = rand_mode ? PW'(state % KV) : fix_plane;
    end

endmodule

// File: rtl/ipc_probe_ctrl.sv
// Module: input port probe-acknowledge controller (top).
// Queues arriving cells and, once per slot, probes the fabric for the head
// cell's outlet on a chosen plane. It sends the head cell in the data phase
// only after an acknowledgment on that plane.
// Assumes the fabric returns acknowledgments within the ACK_WAIT window.
module ipc_probe_ctrl
    import ipc_pkg::*;
#(
    parameter int K        = 4,
    parameter int PW       = (K > 1) ? $clog2(K) : 1,
    parameter int OUT_W    = 3,
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 4,
    parameter int ACK_WAIT = 2,
    parameter int DROP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEQ_W-1:0]  lfsr_seed,
    input  logic              load_mode,
    input  logic [PW-1:0]     fix_plane,
    input  logic              in_valid,
    input  logic [OUT_W-1:0]  in_outlet,
    input  logic [DATA_W-1:0] in_data,
    output logic              slot_start,
    output logic              probe_valid,
    output logic [OUT_W-1:0]  probe_outlet,
    output logic [PW-1:0]     probe_plane,
    input  logic              ack_valid,
    input  logic [PW-1:0]     ack_plane,
    output logic              tx_valid,
    output logic [OUT_W-1:0]  tx_outlet,
    output logic [DATA_W-1:0] tx_data,
    output logic [PW-1:0]     tx_plane,
    output logic [DROP_W-1:0] drop_cnt
);
    localparam int CELL_W = OUT_W + DATA_W;

    logic              in_wait;
    logic              in_xmit;
    logic              q_empty;
    logic              q_full;
    logic              q_wr;
    logic              q_rd;
    logic [CELL_W-1:0] q_head;
    logic [PW-1:0]     sel_plane;
    logic [PW-1:0]     cur_plane;
    logic              probed;
    logic              ack_seen;
    logic              drop_hit;

    ipc_slot_fsm #(.ACK_WAIT(ACK_WAIT)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_start (slot_start),
        .in_wait    (in_wait),
        .in_xmit    (in_xmit)
    );

    ipc_fifo #(.W(CELL_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q_wr),
        .wr_data ({in_outlet, in_data}),
        .rd_en   (q_rd),
        .head    (q_head),
        .empty   (q_empty),
        .full    (q_full)
    );

    ipc_plane_sel #(.K(K), .PW(PW)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed      (lfsr_seed),
        .advance   (slot_start),
        .rand_mode (load_mode),
        .fix_plane (fix_plane),
        .plane     (sel_plane)
    );

    // Arrival admission, probe issue and transmit decode.
    always_comb begin
        q_wr         = slot_start && in_valid && !q_full;
        drop_hit     = slot_start && in_valid && q_full;
        probe_valid  = slot_start && !q_empty;
        probe_outlet = q_head[CELL_W-1 -: OUT_W];
        probe_plane  = sel_plane;
        tx_valid     = in_xmit && ack_seen;
        q_rd         = tx_valid;
        tx_outlet    = q_head[CELL_W-1 -: OUT_W];
        tx_data      = q_head[DATA_W-1:0];
        tx_plane     = cur_plane;
    end

    // Per-slot path record and acknowledgment capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_plane <= '0;
            probed    <= 1'b0;
            ack_seen  <= 1'b0;
        end else if (slot_start) begin
            cur_plane <= sel_plane;
            probed    <= probe_valid;
            ack_seen  <= 1'b0;
        end else if (in_wait && probed && ack_valid && (ack_plane == cur_plane)) begin
            ack_seen <= 1'b1;
        end
    end

    // Saturating count of arrivals lost to a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drop_cnt <= '0;
        end else if (drop_hit && (drop_cnt != '1)) begin
            drop_cnt <= drop_cnt + DROP_W'(1);
        end
    end

endmodule

// File: rtl/ipc_probe_ctrl_chk.sv
// Module: protocol checker for ipc_probe_ctrl, attached by bind.
// Tracks slot position from slot_start with its own counter.
module ipc_probe_ctrl_chk #(
    parameter int PW       = 2,
    parameter int ACK_WAIT = 2,
    parameter int DROP_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_start,
    input logic              probe_valid,
    input logic [PW-1:0]     probe_plane,
    input logic              load_mode,
    input logic [PW-1:0]     fix_plane,
    input logic              tx_valid,
    input logic [PW-1:0]     tx_plane,
    input logic [DROP_W-1:0] drop_cnt
);
    localparam int SLOT_LEN = ACK_WAIT + 2;
    localparam int CNW      = $clog2(SLOT_LEN + 1);

    logic [CNW-1:0] cnt;
    logic           started;
    logic [PW-1:0]  lat_plane;
    logic           lat_probed;

    // Slot position and the probe seen at its start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            started    <= 1'b0;
            lat_plane  <= '0;
            lat_probed <= 1'b0;
        end else if (slot_start) begin
            cnt        <= CNW'(1);
            started    <= 1'b1;
            lat_plane  <= probe_plane;
            lat_probed <= probe_valid;
        end else begin
            cnt <= cnt + CNW'(1);
        end
    end

    assert_slot_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && started) |-> (cnt == CNW'(SLOT_LEN)));

    assert_slot_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (started && cnt == CNW'(SLOT_LEN)) |-> slot_start);

    assert_probe_first_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        probe_valid |-> slot_start);

    assert_tx_data_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (cnt == CNW'(SLOT_LEN - 1)));

    assert_tx_same_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (lat_probed && tx_plane == lat_plane));

    assert_fixed_plane_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_valid && !load_mode) |-> (probe_plane == fix_plane));

    assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + DROP_W'(1)));

    assert_drop_after_probe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_cnt != $past(drop_cnt)) |-> $past(slot_start));

endmodule

bind ipc_probe_ctrl ipc_probe_ctrl_chk #(
    .PW       (PW),
    .ACK_WAIT (ACK_WAIT),
    .DROP_W   (DROP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_start  (slot_start),
    .probe_valid (probe_valid),
    .probe_plane (probe_plane),
    .load_mode   (load_mode),
    .fix_plane   (fix_plane),
    .tx_valid    (tx_valid),
    .tx_plane    (tx_plane),
    .drop_cnt    (drop_cnt)
);

// File: tb/ipc_probe_ctrl_tb.sv
// Bench: reference queue, drop counter and plane sequence, driven slot by slot.
module ipc_probe_ctrl_tb;
    localparam int K        = 4;
    localparam int PW       = 2;
    localparam int OUT_W    = 3;
    localparam int DATA_W   = 8;
    localparam int DEPTH    = 4;
    localparam int ACK_WAIT = 2;
    localparam int DROP_W   = 8;
    localparam int CELL_W   = OUT_W + DATA_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       lfsr_seed = 16'hACE1;
    logic              load_mode = 1'b0;
    logic [PW-1:0]     fix_plane = '0;
    logic              in_valid = 1'b0;
    logic [OUT_W-1:0]  in_outlet = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              slot_start;
    logic              probe_valid;
    logic [OUT_W-1:0]  probe_outlet;
    logic [PW-1:0]     probe_plane;
    logic              ack_valid = 1'b0;
    logic [PW-1:0]     ack_plane = '0;
    logic              tx_valid;
    logic [OUT_W-1:0]  tx_outlet;
    logic [DATA_W-1:0] tx_data;
    logic [PW-1:0]     tx_plane;
    logic [DROP_W-1:0] drop_cnt;

    int                nchk = 0;
    int                nfail = 0;
    logic [CELL_W-1:0] mq[$];
    logic [15:0]       m_seq;
    int                m_drop = 0;

    always #10 clk = ~clk;

    ipc_probe_ctrl #(
        .K(K), .PW(PW), .OUT_W(OUT_W), .DATA_W(DATA_W),
        .DEPTH(DEPTH), .ACK_WAIT(ACK_WAIT), .DROP_W(DROP_W)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .lfsr_seed(lfsr_seed), .load_mode(load_mode),
        .fix_plane(fix_plane), .in_valid(in_valid), .in_outlet(in_outlet),
        .in_data(in_data), .slot_start(slot_start), .probe_valid(probe_valid),
        .probe_outlet(probe_outlet), .probe_plane(probe_plane),
        .ack_valid(ack_valid), .ack_plane(ack_plane), .tx_valid(tx_valid),
        .tx_outlet(tx_outlet), .tx_data(tx_data), .tx_plane(tx_plane),
        .drop_cnt(drop_cnt)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R10 sequence, written from the requirement.
    function automatic logic [15:0] seq_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // ack kinds: 0 none, 1 correct in wait, 2 wrong plane, 3 in data cycle, 4 in probe cycle
    task automatic run_slot(input int arr_pct, input int kind, input bit mode,
                            input logic [PW-1:0] fp);
        logic [PW-1:0] eplane;
        bit            probed;
        bit            ack_ok;
        int            ack_cyc;
        string         tag;
        eplane       = mode ? PW'(m_seq % K) : fp;
        probed       = (mq.size() > 0);
        load_mode    = mode;
        fix_plane    = fp;
        ack_valid    = (kind == 4);
        ack_plane    = eplane;
        in_valid     = (($urandom % 100) < arr_pct);
        in_outlet    = OUT_W'($urandom);
        in_data      = DATA_W'($urandom);
        #1;
        chk("R2 slot_start in probe cycle", slot_start, 1);
        chk("R3/R7 probe_valid", probe_valid, probed);
        if (probed) begin
            chk("R3/R6 probe_outlet", probe_outlet, mq[0][CELL_W-1 -: OUT_W]);
            if (mode) chk("R10 random plane", probe_plane, eplane);
            else      chk("R9 fixed plane", probe_plane, eplane);
        end
        chk("R8 drop_cnt", drop_cnt, m_drop);
        @(posedge clk);
        if (in_valid) begin
            if (mq.size() == DEPTH) begin
                if (m_drop < 255) m_drop++;
            end else begin
                mq.push_back({in_outlet, in_data});
            end
        end
        m_seq   = seq_next(m_seq);
        ack_ok  = 1'b0;
        ack_cyc = int'($urandom % ACK_WAIT);
        for (int j = 0; j < ACK_WAIT; j++) begin
            @(negedge clk);
            in_valid  = $urandom % 2 == 0;
            in_outlet = OUT_W'($urandom);
            in_data   = DATA_W'($urandom);
            ack_valid = 1'b0;
            ack_plane = PW'($urandom);
            if (j == ack_cyc && kind == 1) begin
                ack_valid = 1'b1;
                ack_plane = eplane;
            end else if (j == ack_cyc && kind == 2) begin
                ack_valid = 1'b1;
                ack_plane = eplane + PW'(1);
            end
            #1;
            chk("R2 slot_start in wait", slot_start, 0);
            chk("R3 no probe in wait", probe_valid, 0);
            chk("R5 no tx in wait", tx_valid, 0);
            if (ack_valid && ack_plane == eplane && probed) ack_ok = 1'b1;
            @(posedge clk);
        end
        @(negedge clk);
        in_valid  = 1'b1;
        ack_valid = (kind == 3);
        ack_plane = eplane;
        #1;
        chk("R2 slot_start in data cycle", slot_start, 0);
        if (!probed)     tag = "R11 tx_valid empty";
        else if (ack_ok) tag = "R5 tx_valid acked";
        else             tag = "R4/R6 tx_valid unacked";
        chk(tag, tx_valid, ack_ok);
        if (ack_ok) begin
            chk("R5 tx_outlet", tx_outlet, mq[0][CELL_W-1 -: OUT_W]);
            chk("R5 tx_data", tx_data, mq[0][DATA_W-1:0]);
            chk("R5 tx_plane", tx_plane, eplane);
        end
        @(posedge clk);
        if (ack_ok) void'(mq.pop_front());
        @(negedge clk);
        ack_valid = 1'b0;
        in_valid  = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int pct;
        void'($urandom(32'd4321));
        m_seq = lfsr_seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 slot_start after reset", slot_start, 1);
        chk("R1 probe_valid after reset", probe_valid, 0);
        chk("R1 tx_valid after reset", tx_valid, 0);
        chk("R1 drop_cnt after reset", drop_cnt, 0);
        // R4/R11: acknowledgments while empty
        repeat (3) run_slot(0, 1, 1'b0, 2'd1);
        // R6: one cell, retried, then wrong-plane, data-cycle and probe-cycle acks, then a good one
        run_slot(100, 0, 1'b0, 2'd2);
        repeat (3) run_slot(0, 0, 1'b0, 2'd2);
        run_slot(0, 2, 1'b0, 2'd2);
        run_slot(0, 3, 1'b0, 2'd2);
        run_slot(0, 4, 1'b0, 2'd2);
        run_slot(0, 1, 1'b0, 2'd2);
        // R8: fill past DEPTH, then full queue with a leaving head
        repeat (8) run_slot(100, 0, 1'b0, 2'd3);
        repeat (2) run_slot(100, 1, 1'b0, 2'd3);
        repeat (6) run_slot(0, 1, 1'b0, 2'd0);
        // R10: random loading with steady acks
        repeat (20) run_slot(60, 1, 1'b1, 2'd0);
        // mixed random traffic, fixed then random mode
        for (int i = 0; i < 600; i++) begin
            pct = (i % 3 == 0) ? 20 : ((i % 3 == 1) ? 50 : 90);
            run_slot(pct, int'($urandom % 5), i >= 300, PW'($urandom));
        end
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule